// File: doc/BRIEF.md
# Bused Register-File Datapath with Status Flags

This block is the execution half of a small 8-bit processor. Seven general registers feed two source multiplexers. Each multiplexer can also pick an external data word instead of a register. The two selected operands drive a shared ALU. The ALU result is always visible on an external output port, and it can be written back into any one of the seven registers.

A 14-bit control word arrives every clock cycle and fully defines what happens in that cycle. The word is built by a sequencer outside this block; sequencing and instruction fetch are not part of it. The block has no handshake: the word present before a rising edge is the one that edge commits.

A 4-bit status register records carry, sign, zero and overflow for the operation of each cycle. The register write and the status load happen on the same rising edge.

Top module: `gr_datapath`

## Requirements
- R1: The control word is split into four fields: A-source select in bits 13:11, B-source select in bits 10:8, destination select in bits 7:5, and ALU operation in bits 4:0.
- R2: A source-select code from 1 to 7 places register R1 to R7 on that operand bus. Both the A and B selects decode the same way.
- R3: A source-select code of 0 places the `ext_in` word on that operand bus.
- R4: A destination code from 1 to 7 loads the ALU result into R1 to R7 on the rising edge. All other registers keep their values.
- R5: A destination code of 0 loads no register, while `ext_out` still carries the ALU result.
- R6: `ext_out` equals the ALU result for the current control word and current register contents, with no clock delay.
- R7: The arithmetic operation codes are as follows. 00010 gives A+B. 00101 gives A-B, computed as A plus the two's complement of B. 00001 gives A+1. 00110 gives A-1. All arithmetic wraps modulo 256.
- R8: The other operation codes are as follows. 00000 passes A. 01000 gives AND, 01010 gives OR and 01100 gives XOR. 01110 gives the complement of A. 10000 shifts A right with 0 in, and 11000 shifts A left with 0 in. Any other code passes A.
- R9: For arithmetic codes, C is the carry out of bit 7. For subtraction, C=1 means no borrow: 0xF0 minus 0x14 gives 0xDC with C=1, S=1, Z=0, V=0.
- R10: For arithmetic codes, V is the XOR of the carry into bit 7 and the carry out of bit 7.
- R11: For every operation code, S equals result bit 7, and Z is 1 exactly when the 8-bit result is zero.
- R12: For transfer, logic, shift and undefined codes, C and V are loaded as 0.
- R13: `flags_out` holds {C,S,Z,V} in bits 3 down to 0. The flags are loaded on every rising edge outside reset, on the same edge as the register write.
- R14: While `rst` is high at a rising edge, all seven registers and all four flags are cleared. Reset takes priority over any write the control word requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 14 | Per-cycle control word (A select, B select, destination, operation) |
| ext_in | input | 8 | External data word, selectable as either operand |
| ext_out | output | 8 | ALU result of the current cycle |
| flags_out | output | 4 | Status register {C,S,Z,V} |

## Verification
The datapath is tried with several kinds of control word.

Loads through the external input with a transfer code confirm that source code 0 and every destination code reach the right register. Reading each register back through both the A bus and the B bus separates a wrong select decode from a wrong write decode.

Arithmetic words use operand pairs chosen at the carry and overflow boundaries: 0x7F+1, 0xFF+1, 0x00-1, 0x80-1, and the 0xF0-0x14 case. These pairs separate a wrong carry chain from a wrong overflow rule. Logic, shift and undefined codes run on operands whose previous flags had C or V set, to show the clearing.

Words with destination 0, and a reset asserted while a write is requested, show that `ext_out` still moves while no register changes.

// File: rtl/gr_pkg.sv
package gr_pkg;

  localparam int DW    = 8;
  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int NREG  = (1 << SEL_W) - 1;
  localparam int CW_W  = 3 * SEL_W + OP_W;
  localparam int FL_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dest;
    logic [OP_W-1:0]  op;
  } ctrl_t;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
  } alu_out_t;

  function automatic logic op_is_arith(logic [OP_W-1:0] op);
    return (op == OP_INC) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_DEC);
  endfunction

  // Arithmetic is one adder: a + addend + cin. The carry into the top bit
  // comes from a separate sum of the lower bits.
  function automatic alu_out_t alu_eval(logic [OP_W-1:0] op,
                                        logic [DW-1:0] a,
                                        logic [DW-1:0] b);
    alu_out_t      o;
    logic [DW-1:0] addend;
    logic          cin;
    logic [DW:0]   full;
    logic [DW-1:0] low;
    addend = '0;
    cin    = 1'b0;
    case (op)
      OP_INC: cin = 1'b1;
      OP_ADD: addend = b;
      OP_SUB: begin addend = ~b; cin = 1'b1; end
      OP_DEC: addend = '1;
      default: ;
    endcase
    full = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, cin};
    low  = {1'b0, a[DW-2:0]} + {1'b0, addend[DW-2:0]} + {{(DW-1){1'b0}}, cin};
    o.c = 1'b0;
    o.v = 1'b0;
    if (op_is_arith(op)) begin
      o.res = full[DW-1:0];
      o.c   = full[DW];
      o.v   = full[DW] ^ low[DW-1];
    end else begin
      case (op)
        OP_AND:  o.res = a & b;
        OP_OR:   o.res = a | b;
        OP_XOR:  o.res = a ^ b;
        OP_NOT:  o.res = ~a;
        OP_SHR:  o.res = a >> 1;
        OP_SHL:  o.res = a << 1;
        default: o.res = a;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/gr_regfile.sv
module gr_regfile
  import gr_pkg::*;
#(
  parameter int W  = DW,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] src_a,
  input  logic [SW-1:0] src_b,
  input  logic [SW-1:0] dest,
  input  logic [W-1:0]  ext_in,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  bus_a,
  output logic [W-1:0]  bus_b
);
  localparam int N = (1 << SW) - 1;

  logic [N:1][W-1:0] regs_q;
  logic [N:1]        wr_hit;

  for (genvar i = 1; i <= N; i++) begin : g_reg
    assign wr_hit[i] = (dest == SW'(i));
    always_ff @(posedge clk) begin
      if (rst)            regs_q[i] <= '0;
      else if (wr_hit[i]) regs_q[i] <= wr_data;
    end
  end

  always_comb begin
    bus_a = ext_in;
    bus_b = ext_in;
    for (int k = 1; k <= N; k++) begin
      if (src_a == SW'(k)) bus_a = regs_q[k];
      if (src_b == SW'(k)) bus_b = regs_q[k];
    end
  end

  // R5: destination code 0 leaves every register untouched
  p_no_dest_r5: assert property (@(posedge clk) disable iff (rst)
    (dest == '0) |=> $stable(regs_q));

  // R4: a nonzero destination captures the write data
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (dest != '0) |=> regs_q[$past(dest)] == $past(wr_data));

endmodule

// File: rtl/gr_alu.sv
module gr_alu
  import gr_pkg::*;
#(
  parameter int W  = DW,
  parameter int OW = OP_W
) (
  input  logic [OW-1:0] op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  result,
  output flags_t        flags_nxt
);
  alu_out_t ev;

  always_comb begin
    ev          = alu_eval(op, a, b);
    result      = ev.res;
    flags_nxt.c = ev.c;
    flags_nxt.v = ev.v;
    flags_nxt.s = ev.res[W-1];
    flags_nxt.z = (ev.res == '0);
  end

endmodule

// File: rtl/gr_status.sv
module gr_status
  import gr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t flags_d,
  output flags_t flags_q
);
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/gr_datapath.sv
module gr_datapath
  import gr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [DW-1:0]   ext_in,
  output logic [DW-1:0]   ext_out,
  output logic [FL_W-1:0] flags_out
);
  ctrl_t         cw;
  logic [DW-1:0] bus_a;
  logic [DW-1:0] bus_b;
  logic [DW-1:0] alu_res;
  flags_t        fl_nxt;
  flags_t        fl_q;

  assign cw = ctrl_t'(ctrl_word);

  gr_regfile #(.W(DW), .SW(SEL_W)) u_rf (
    .clk(clk), .rst(rst),
    .src_a(cw.src_a), .src_b(cw.src_b), .dest(cw.dest),
    .ext_in(ext_in), .wr_data(alu_res),
    .bus_a(bus_a), .bus_b(bus_b)
  );

  gr_alu #(.W(DW), .OW(OP_W)) u_alu (
    .op(cw.op), .a(bus_a), .b(bus_b),
    .result(alu_res), .flags_nxt(fl_nxt)
  );

  gr_status u_st (
    .clk(clk), .rst(rst), .flags_d(fl_nxt), .flags_q(fl_q)
  );

  assign ext_out   = alu_res;
  assign flags_out = fl_q;

  // R11: the stored zero and sign flags agree with the result driven out
  p_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fl_q.z == ($past(ext_out) == '0));
  p_sign_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fl_q.s == $past(ext_out[DW-1]));

  // R12: non-arithmetic codes leave C and V cleared
  p_clear_cv_r12: assert property (@(posedge clk) disable iff (rst)
    !op_is_arith(cw.op) |=> !fl_q.c && !fl_q.v);

  // R10: adding operands of opposite sign never overflows
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (cw.op == OP_ADD && bus_a[DW-1] != bus_b[DW-1]) |=> !fl_q.v);

endmodule

// File: tb/sim_gr_datapath.sv
module sim_gr_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  ext_out;
  logic [3:0]  flags_out;

  always #5 clk = ~clk;

  gr_datapath u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
    .ext_in(ext_in), .ext_out(ext_out), .flags_out(flags_out)
  );

  typedef struct {
    logic [7:0] eo;
    logic [3:0] ef;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] mreg[8];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 0;

  // Reference model: returns {C,S,Z,V,result}
  function automatic logic [11:0] ref_op(logic [4:0] op, logic [7:0] a, logic [7:0] b);
    logic [7:0] y;
    bit c = 0, v = 0;
    int ua = int'(a), ub = int'(b);
    case (op)
      5'b00010: begin y = 8'(ua + ub); c = (ua + ub) > 255; v = (a[7] == b[7]) && (y[7] != a[7]); end
      5'b00101: begin y = 8'(ua - ub); c = (ua >= ub);      v = (a[7] != b[7]) && (y[7] != a[7]); end
      5'b00001: begin y = 8'(ua + 1);  c = (a == 8'hFF);    v = (a == 8'h7F); end
      5'b00110: begin y = 8'(ua - 1);  c = (a != 8'h00);    v = (a == 8'h80); end
      5'b01000: y = a & b;
      5'b01010: y = a | b;
      5'b01100: y = a ^ b;
      5'b01110: y = 8'hFF - a;
      5'b10000: y = 8'(ua / 2);
      5'b11000: y = 8'(ua * 2);
      default:  y = a;
    endcase
    return {c, y[7], (y == 8'h00), v, y};
  endfunction

  task automatic step(input logic [2:0] sa, input logic [2:0] sbs, input logic [2:0] sd,
                      input logic [4:0] op, input logic [7:0] x, input string tag);
    logic [7:0]  a, b;
    logic [11:0] r;
    item_t       it;
    @(negedge clk); #1;
    ctrl_word = {sa, sbs, sd, op};
    ext_in    = x;
    a = (sa  == 3'd0) ? x : mreg[sa];
    b = (sbs == 3'd0) ? x : mreg[sbs];
    r = ref_op(op, a, b);
    it.eo = r[7:0]; it.ef = r[11:8]; it.tag = tag;
    sb_q.push_back(it);
    if (sd != 3'd0) mreg[sd] = r[7:0];
  endtask

  task automatic read_all(input string tag);
    for (int i = 1; i < 8; i++) step(3'(i), 3'd0, 3'd0, 5'b00000, 8'h00, tag);
  endtask

  task automatic do_reset();
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b1;
    ctrl_word = {3'd0, 3'd0, 3'd1, 5'b00000};
    ext_in = 8'hA5;
    @(negedge clk); #1;
    rst = 1'b0;
    ctrl_word = '0;
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    #1;
    n_chk++;
    if (flags_out !== 4'h0) begin
      n_bad++;
      $display("FAIL R14 flags after reset act=%h exp=%h", flags_out, 4'h0);
    end
  endtask

  // Monitor: result before the edge, flags after it
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #3;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (ext_out !== it.eo) begin
          n_bad++;
          $display("FAIL %s ext_out act=%h exp=%h", it.tag, ext_out, it.eo);
        end
        @(posedge clk); #1;
        n_chk++;
        if (flags_out !== it.ef) begin
          n_bad++;
          $display("FAIL %s/R13 flags act=%b exp=%b", it.tag, flags_out, it.ef);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    #1;
    n_chk++;
    if (flags_out !== 4'h0) begin
      n_bad++;
      $display("FAIL R14 initial flags act=%h exp=%h", flags_out, 4'h0);
    end
    read_all("R14");
    // Load registers through the external input (R1 field layout, R3, R4)
    step(3'd0, 3'd0, 3'd1, 5'b00000, 8'hF0, "R1 R3 R4");
    step(3'd0, 3'd0, 3'd2, 5'b00000, 8'h14, "R3 R4");
    step(3'd0, 3'd0, 3'd3, 5'b00000, 8'h7F, "R3 R4");
    step(3'd0, 3'd0, 3'd4, 5'b00000, 8'h01, "R3 R4");
    step(3'd0, 3'd0, 3'd5, 5'b00000, 8'h80, "R3 R4");
    step(3'd0, 3'd0, 3'd6, 5'b00000, 8'hFF, "R3 R4");
    step(3'd0, 3'd0, 3'd7, 5'b00000, 8'h55, "R3 R4");
    // B-bus select of every register: ext 0 + Ri
    for (int i = 1; i < 8; i++) step(3'd0, 3'(i), 3'd0, 5'b00010, 8'h00, "R2");
    // Arithmetic boundaries
    step(3'd1, 3'd2, 3'd0, 5'b00101, 8'h00, "R9 R6 R7");
    step(3'd3, 3'd4, 3'd0, 5'b00010, 8'h00, "R10 R5");
    step(3'd6, 3'd4, 3'd0, 5'b00010, 8'h00, "R9 R11");
    step(3'd0, 3'd0, 3'd0, 5'b00001, 8'hFF, "R7 R9");
    step(3'd0, 3'd0, 3'd0, 5'b00001, 8'h7F, "R7 R10");
    step(3'd0, 3'd0, 3'd0, 5'b00110, 8'h00, "R7 R9");
    step(3'd0, 3'd0, 3'd0, 5'b00110, 8'h80, "R7 R10");
    step(3'd5, 3'd0, 3'd0, 5'b00101, 8'h01, "R3 R10");
    step(3'd4, 3'd5, 3'd0, 5'b00101, 8'h00, "R9 R10");
    // Logic, shift and undefined codes after flags with C/V set
    step(3'd6, 3'd4, 3'd0, 5'b00010, 8'h00, "R9");
    step(3'd7, 3'd1, 3'd2, 5'b01000, 8'h00, "R8 R12");
    step(3'd5, 3'd0, 3'd0, 5'b00110, 8'h80, "R10");
    step(3'd7, 3'd4, 3'd3, 5'b01010, 8'h00, "R8 R12");
    step(3'd1, 3'd7, 3'd0, 5'b01100, 8'h00, "R8 R11");
    step(3'd6, 3'd0, 3'd0, 5'b01110, 8'h00, "R8 R11");
    step(3'd4, 3'd0, 3'd4, 5'b10000, 8'h00, "R8 R11");
    step(3'd5, 3'd0, 3'd0, 5'b11000, 8'h00, "R8 R11");
    step(3'd1, 3'd2, 3'd0, 5'b11111, 8'h00, "R8 R12");
    step(3'd0, 3'd0, 3'd0, 5'b00011, 8'h9C, "R8 R12");
    read_all("R2 R4 R5");
    // Reset while a write is requested
    do_reset();
    read_all("R14");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule